// File: doc/BRIEF.md
# Receive Descriptor Ring Walker

This engine sits on the memory side of a network receiver. It stores incoming frame bytes in host buffers. The host describes those buffers with a circular table of descriptors in a 16-bit word-addressed memory. Each descriptor occupies 8 bytes. The host marks a descriptor as usable by setting its ownership flag. The engine fetches a descriptor's buffer address and capacity, then packs received bytes into that buffer. When a frame is longer than one buffer, the engine carries the frame on into the next descriptor. As it finishes each descriptor it returns it to the host by clearing the ownership flag, and it records where each frame starts and ends.

Frames arrive as a byte stream with valid/ready handshaking, plus start, end and error markers. A byte transfers on a rising clock edge when `in_valid` and `in_ready` are both high. The source must hold the byte and its markers stable until that edge. The engine lowers `in_ready` in two cases: while it reads or writes descriptors, and while the current buffer is full and the next descriptor has not yet been checked. It never drops a byte of a frame that has a buffer. The memory port is single-ported and issues one request per cycle. Read data arrives on `mem_rdata` in the cycle after the request.

Two one-cycle event outputs report progress. One signals a completed frame. The other signals a frame that lost its storage.

Top module: `rx_ring_walker`

## Requirements
- R1: Descriptor i sits at byte address 8*(`ring_base_blk`+i), and its 16-bit words 0..3 hold these fields in order: buffer address bits 15:0; {flags byte in bits 15:8, buffer address bits 23:16 in bits 7:0}; buffer capacity in bytes; message length. The index starts at 0 after reset. After the last descriptor it wraps modulo 2^`ring_log2`.
- R2: The engine may use a descriptor only when its ownership flag (flags bit 7, value 0x80) is set. If a frame starts while the current descriptor is not owned, the engine consumes and discards the whole frame, pulses `rx_miss` for one cycle, writes nothing, and keeps the index.
- R3: Byte k of a buffer goes to byte address buf+k, where buf is even. Each memory word packs the even byte in bits 7:0 and the odd byte in bits 15:8. A lone trailing byte is written with `mem_be`=01, which leaves the upper half untouched.
- R4: A frame longer than a buffer's capacity continues in the next owned descriptor. The start flag (0x02) appears only on the first descriptor of a frame. The end flag (0x01) appears only on the last. Intermediate descriptors carry flags 0x00.
- R5: Word 3 (message length) is written only in the end descriptor, and it holds the frame's total byte count. No other descriptor's word 3 changes.
- R6: Each descriptor the engine returns gets word 1 rewritten with the ownership flag cleared, and this is the last write to that descriptor. The engine keeps the address-high byte in the rewritten word.
- R7: If a frame overruns a buffer while the next descriptor is not owned, the engine does four things: the current descriptor gets error 0x40 plus no-buffer 0x04 (and 0x02 if it is the first) and no end flag; the rest of the frame is discarded; `rx_miss` pulses once; and the index moves past the current descriptor only.
- R8: If `in_err` is high on the end byte of a frame, the end descriptor also carries error 0x40 and CRC error 0x08.
- R9: `rx_done` pulses for exactly one cycle per completed frame, after that frame's descriptor write-backs. `rx_done` and `rx_miss` are never high in the same cycle.
- R10: In idle, `in_ready` equals `!in_sof`. Bytes that arrive outside a frame are accepted and discarded without any memory write. `in_ready` is low in every cycle that issues a memory read.
- R11: When a frame's end byte exactly fills a buffer, that buffer is closed with the end flag. The engine never reads the following descriptor in that case, so an unowned neighbour causes no miss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| ring_base_blk | input | 21 | Ring base address in units of 8 bytes |
| ring_log2 | input | 3 | Ring length exponent; the ring holds 2^n descriptors |
| in_valid | input | 1 | Stream byte valid |
| in_ready | output | 1 | Engine accepts the stream byte this cycle |
| in_data | input | 8 | Stream byte |
| in_sof | input | 1 | Byte is the first of a frame |
| in_eof | input | 1 | Byte is the last of a frame |
| in_err | input | 1 | Frame failed its check; sampled with in_eof |
| mem_req | output | 1 | Memory request this cycle |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 23 | Memory word address |
| mem_be | output | 2 | Byte enables of a write (bit 0 = bits 7:0) |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, valid the cycle after a read request |
| rx_done | output | 1 | One-cycle pulse per completed frame |
| rx_miss | output | 1 | One-cycle pulse per frame that lost its storage |

## Verification
The end of a frame and the exhaustion of its buffer can land on the same byte. On that byte the engine must decide between closing the descriptor and probing the next one. The bench provokes this case with frames whose length equals a buffer's capacity, once in the regular sequence and once with the following descriptor deliberately left unowned. The verdict depends on three observations: the end flag and message length land in the filled descriptor, no miss event fires, and the next frame starts at the neighbour.

// File: rtl/rxr_pkg.sv
package rxr_pkg;

  // Byte address carried by a descriptor: 16 low bits plus 8 high bits.
  localparam int ADDR_W = 24;
  localparam int WORD_W = 16;
  localparam int WA_W   = ADDR_W - 1;   // word address
  localparam int BLK_W  = ADDR_W - 3;   // 8-byte descriptor slot address

  // Descriptor word offsets (the host decodes these).
  localparam logic [1:0] DW_ADDR  = 2'd0;
  localparam logic [1:0] DW_FLAGS = 2'd1;
  localparam logic [1:0] DW_CAP   = 2'd2;
  localparam logic [1:0] DW_MLEN  = 2'd3;

  // Flag byte bits.
  localparam logic [7:0] FL_OWN  = 8'h80;
  localparam logic [7:0] FL_ERR  = 8'h40;
  localparam logic [7:0] FL_CRC  = 8'h08;
  localparam logic [7:0] FL_BUFF = 8'h04;
  localparam logic [7:0] FL_STP  = 8'h02;
  localparam logic [7:0] FL_ENP  = 8'h01;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_F_FLG,
    ST_F_LO,
    ST_F_CAP,
    ST_F_GO,
    ST_STRM,
    ST_CL_FLUSH,
    ST_CL_MLEN,
    ST_CL_FLG,
    ST_NX_FLUSH,
    ST_NX_RD,
    ST_NX_CHK,
    ST_DROP
  } walk_st_e;

endpackage

// File: rtl/rxr_ring_index.sv
module rxr_ring_index #(
  parameter int EXP_W = 3,
  parameter int IDX_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [EXP_W-1:0] ring_log2,
  input  logic             step,
  output logic [IDX_W-1:0] cur_idx,
  output logic [IDX_W-1:0] nxt_idx
);

  logic [IDX_W-1:0] mask;

  for (genvar b = 0; b < IDX_W; b++) begin : g_mask
    assign mask[b] = (32'(ring_log2) > b);
  end

  assign nxt_idx = (cur_idx + IDX_W'(1)) & mask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_idx <= '0;
    end else if (step) begin
      cur_idx <= nxt_idx;
    end
  end

endmodule

// File: rtl/rxr_byte_packer.sv
module rxr_byte_packer #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic              clr,
  input  logic [BYTE_W-1:0] din,
  output logic              has_pend,
  output logic [BYTE_W-1:0] pend_byte
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      has_pend  <= 1'b0;
      pend_byte <= '0;
    end else if (clr) begin
      has_pend <= 1'b0;
    end else if (push) begin
      if (has_pend) begin
        has_pend <= 1'b0;
      end else begin
        has_pend  <= 1'b1;
        pend_byte <= din;
      end
    end
  end

endmodule

// File: rtl/rxr_walk_ctrl.sv
module rxr_walk_ctrl
  import rxr_pkg::*;
#(
  parameter int IDX_W = 7,
  parameter int CNT_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [BLK_W-1:0]   ring_base_blk,
  input  logic [IDX_W-1:0]   cur_idx,
  input  logic [IDX_W-1:0]   nxt_idx,
  output logic               idx_step,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [7:0]         in_data,
  input  logic               in_sof,
  input  logic               in_eof,
  input  logic               in_err,
  output logic               pk_push,
  output logic               pk_clr,
  input  logic               pk_has_pend,
  input  logic [7:0]         pk_pend,
  output logic               mem_req,
  output logic               mem_we,
  output logic [WA_W-1:0]    mem_addr,
  output logic [1:0]         mem_be,
  output logic [WORD_W-1:0]  mem_wdata,
  input  logic [WORD_W-1:0]  mem_rdata,
  output logic               rx_done,
  output logic               rx_miss
);

  walk_st_e         st, st_d;
  logic [WA_W-1:0]  buf_wa, wa_d;
  logic [CNT_W-1:0] buf_used, used_d;
  logic [CNT_W-1:0] buf_cap, cap_d;
  logic [CNT_W-1:0] frm_len, len_d;
  logic [7:0]       hadr, hadr_d;
  logic             first, first_d;
  logic             crc, crc_d;
  logic             done_d, miss_d;
  logic             own_rd, full;
  logic [7:0]       stp_fl;

  function automatic logic [WA_W-1:0] dwa(input logic [BLK_W-1:0] base,
                                          input logic [IDX_W-1:0] i,
                                          input logic [1:0] w);
    return {base + BLK_W'(i), w};
  endfunction

  assign own_rd = mem_rdata[15];
  assign full   = (buf_used == buf_cap);
  assign stp_fl = first ? FL_STP : 8'h00;

  always_comb begin
    st_d      = st;
    wa_d      = buf_wa;
    used_d    = buf_used;
    cap_d     = buf_cap;
    len_d     = frm_len;
    hadr_d    = hadr;
    first_d   = first;
    crc_d     = crc;
    done_d    = 1'b0;
    miss_d    = 1'b0;
    idx_step  = 1'b0;
    in_ready  = 1'b0;
    pk_push   = 1'b0;
    pk_clr    = 1'b0;
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = '0;
    mem_be    = 2'b11;
    mem_wdata = '0;
    unique case (st)
      ST_IDLE: begin
        in_ready = !in_sof;
        if (in_valid && in_sof) begin
          st_d    = ST_F_FLG;
          first_d = 1'b1;
          len_d   = '0;
          crc_d   = 1'b0;
        end
      end
      ST_F_FLG: begin
        mem_req  = 1'b1;
        mem_addr = dwa(ring_base_blk, cur_idx, DW_FLAGS);
        st_d     = ST_F_LO;
      end
      ST_F_LO: begin
        if (!own_rd) begin
          miss_d = 1'b1;
          st_d   = ST_DROP;
        end else begin
          hadr_d   = mem_rdata[7:0];
          mem_req  = 1'b1;
          mem_addr = dwa(ring_base_blk, cur_idx, DW_ADDR);
          st_d     = ST_F_CAP;
        end
      end
      ST_F_CAP: begin
        wa_d     = {hadr, mem_rdata[15:1]};
        mem_req  = 1'b1;
        mem_addr = dwa(ring_base_blk, cur_idx, DW_CAP);
        st_d     = ST_F_GO;
      end
      ST_F_GO: begin
        cap_d  = mem_rdata;
        used_d = '0;
        st_d   = ST_STRM;
      end
      ST_STRM: begin
        in_ready = !full;
        if (in_valid && full) begin
          st_d = pk_has_pend ? ST_NX_FLUSH : ST_NX_RD;
        end else if (in_valid) begin
          pk_push = 1'b1;
          used_d  = buf_used + CNT_W'(1);
          len_d   = frm_len + CNT_W'(1);
          if (pk_has_pend) begin
            mem_req   = 1'b1;
            mem_we    = 1'b1;
            mem_addr  = buf_wa;
            mem_wdata = {in_data, pk_pend};
            wa_d      = buf_wa + WA_W'(1);
          end
          if (in_eof) begin
            crc_d = in_err;
            st_d  = pk_has_pend ? ST_CL_MLEN : ST_CL_FLUSH;
          end
        end
      end
      ST_CL_FLUSH, ST_NX_FLUSH: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = buf_wa;
        mem_be    = 2'b01;
        mem_wdata = {8'h00, pk_pend};
        pk_clr    = 1'b1;
        st_d      = (st == ST_CL_FLUSH) ? ST_CL_MLEN : ST_NX_RD;
      end
      ST_CL_MLEN: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = dwa(ring_base_blk, cur_idx, DW_MLEN);
        mem_wdata = frm_len;
        st_d      = ST_CL_FLG;
      end
      ST_CL_FLG: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = dwa(ring_base_blk, cur_idx, DW_FLAGS);
        mem_wdata = {FL_ENP | stp_fl | (crc ? (FL_ERR | FL_CRC) : 8'h00), hadr};
        idx_step  = 1'b1;
        done_d    = 1'b1;
        st_d      = ST_IDLE;
      end
      ST_NX_RD: begin
        mem_req  = 1'b1;
        mem_addr = dwa(ring_base_blk, nxt_idx, DW_FLAGS);
        st_d     = ST_NX_CHK;
      end
      ST_NX_CHK: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = dwa(ring_base_blk, cur_idx, DW_FLAGS);
        mem_wdata = {stp_fl | (own_rd ? 8'h00 : (FL_ERR | FL_BUFF)), hadr};
        idx_step  = 1'b1;
        if (own_rd) begin
          first_d = 1'b0;
          st_d    = ST_F_FLG;
        end else begin
          miss_d = 1'b1;
          st_d   = ST_DROP;
        end
      end
      ST_DROP: begin
        in_ready = 1'b1;
        if (in_valid && in_eof) st_d = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      buf_wa   <= '0;
      buf_used <= '0;
      buf_cap  <= '0;
      frm_len  <= '0;
      hadr     <= '0;
      first    <= 1'b0;
      crc      <= 1'b0;
      rx_done  <= 1'b0;
      rx_miss  <= 1'b0;
    end else begin
      st       <= st_d;
      buf_wa   <= wa_d;
      buf_used <= used_d;
      buf_cap  <= cap_d;
      frm_len  <= len_d;
      hadr     <= hadr_d;
      first    <= first_d;
      crc      <= crc_d;
      rx_done  <= done_d;
      rx_miss  <= miss_d;
    end
  end

endmodule

// File: rtl/rx_ring_walker.sv
module rx_ring_walker
  import rxr_pkg::*;
#(
  parameter int EXP_W = 3,
  parameter int CNT_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [BLK_W-1:0]   ring_base_blk,
  input  logic [EXP_W-1:0]   ring_log2,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [7:0]         in_data,
  input  logic               in_sof,
  input  logic               in_eof,
  input  logic               in_err,
  output logic               mem_req,
  output logic               mem_we,
  output logic [WA_W-1:0]    mem_addr,
  output logic [1:0]         mem_be,
  output logic [WORD_W-1:0]  mem_wdata,
  input  logic [WORD_W-1:0]  mem_rdata,
  output logic               rx_done,
  output logic               rx_miss
);

  localparam int IDX_W = (1 << EXP_W) - 1;

  logic [IDX_W-1:0] idx_cur, idx_nxt;
  logic             idx_step;
  logic             pk_push, pk_clr, pk_has_pend;
  logic [7:0]       pk_pend;

  rxr_ring_index #(.EXP_W(EXP_W), .IDX_W(IDX_W)) u_index (
    .clk       (clk),
    .rst_n     (rst_n),
    .ring_log2 (ring_log2),
    .step      (idx_step),
    .cur_idx   (idx_cur),
    .nxt_idx   (idx_nxt)
  );

  rxr_byte_packer #(.BYTE_W(8)) u_packer (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (pk_push),
    .clr       (pk_clr),
    .din       (in_data),
    .has_pend  (pk_has_pend),
    .pend_byte (pk_pend)
  );

  rxr_walk_ctrl #(.IDX_W(IDX_W), .CNT_W(CNT_W)) u_ctrl (
    .clk           (clk),
    .rst_n         (rst_n),
    .ring_base_blk (ring_base_blk),
    .cur_idx       (idx_cur),
    .nxt_idx       (idx_nxt),
    .idx_step      (idx_step),
    .in_valid      (in_valid),
    .in_ready      (in_ready),
    .in_data       (in_data),
    .in_sof        (in_sof),
    .in_eof        (in_eof),
    .in_err        (in_err),
    .pk_push       (pk_push),
    .pk_clr        (pk_clr),
    .pk_has_pend   (pk_has_pend),
    .pk_pend       (pk_pend),
    .mem_req       (mem_req),
    .mem_we        (mem_we),
    .mem_addr      (mem_addr),
    .mem_be        (mem_be),
    .mem_wdata     (mem_wdata),
    .mem_rdata     (mem_rdata),
    .rx_done       (rx_done),
    .rx_miss       (rx_miss)
  );

endmodule

// File: rtl/rxr_walker_chk.sv
module rxr_walker_chk #(
  parameter int EXP_W = 3,
  parameter int IDX_W = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic [EXP_W-1:0] ring_log2,
  input logic [IDX_W-1:0] cur_idx,
  input logic             in_ready,
  input logic             mem_req,
  input logic             mem_we,
  input logic [1:0]       mem_be,
  input logic             rx_done,
  input logic             rx_miss
);

  // R1: the ring index never leaves the configured ring
  a_r1_idx_in_ring: assert property (@(posedge clk) disable iff (!rst_n)
    ((32'(cur_idx) >> ring_log2) == 0));

  // R2, R7: a miss event lasts one cycle
  a_r2_miss_single: assert property (@(posedge clk) disable iff (!rst_n)
    rx_miss |=> !rx_miss);

  // R9: a completion event lasts one cycle
  a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done |=> !rx_done);

  // R9: completion and miss never coincide
  a_r9_done_miss_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(rx_done && rx_miss));

  // R10: the stream is stalled whenever the memory is read
  a_r10_stall_on_read: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_we) |-> !in_ready);

  // R3: every write enables at least one byte lane
  a_r3_write_lanes: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> (mem_be != 2'b00));

endmodule

bind rx_ring_walker rxr_walker_chk #(.EXP_W(EXP_W), .IDX_W(IDX_W)) u_walker_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ring_log2 (ring_log2),
  .cur_idx   (idx_cur),
  .in_ready  (in_ready),
  .mem_req   (mem_req),
  .mem_we    (mem_we),
  .mem_be    (mem_be),
  .rx_done   (rx_done),
  .rx_miss   (rx_miss)
);

// File: tb/test_rx_ring_walker.sv
module test_rx_ring_walker;

  localparam int CLK_PERIOD = 10;
  localparam int NDESC      = 4;
  localparam int BASE_BLK   = 32'h20;   // ring at byte 0x100
  localparam int NFRAMES    = 6;
  // {length[24:9], crc error[8], seed[7:0]}
  localparam logic [24:0] FRAMES [NFRAMES] = '{
    {16'd10,  1'b0, 8'h10},
    {16'd41,  1'b1, 8'h30},
    {16'd100, 1'b0, 8'h50},
    {16'd90,  1'b0, 8'h70},
    {16'd70,  1'b1, 8'h90},
    {16'd64,  1'b0, 8'hB0}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0, in_sof = 1'b0, in_eof = 1'b0, in_err = 1'b0;
  logic [7:0]  in_data = 8'h00;
  logic        in_ready, mem_req, mem_we, rx_done, rx_miss;
  logic [22:0] mem_addr;
  logic [1:0]  mem_be;
  logic [15:0] mem_wdata;
  logic [15:0] mem_rdata = 16'h0000;

  logic [15:0] mem [4096];
  int wr_cnt = 0, done_cnt = 0, miss_cnt = 0;
  int n_chk = 0, n_bad = 0;
  int exp_idx = 0;
  bit owned [NDESC];

  always #(CLK_PERIOD/2) clk = ~clk;

  rx_ring_walker i_rx_ring_walker (
    .clk(clk), .rst_n(rst_n), .ring_base_blk(21'(BASE_BLK)), .ring_log2(3'd2),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .in_sof(in_sof), .in_eof(in_eof), .in_err(in_err),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .rx_done(rx_done), .rx_miss(rx_miss));

  // memory model: read data one cycle after request
  always @(posedge clk) begin
    if (mem_req) begin
      if (mem_we) begin
        if (mem_be[0]) mem[mem_addr[11:0]][7:0]  = mem_wdata[7:0];
        if (mem_be[1]) mem[mem_addr[11:0]][15:8] = mem_wdata[15:8];
        wr_cnt <= wr_cnt + 1;
      end else begin
        mem_rdata <= mem[mem_addr[11:0]];
      end
    end
    if (rx_done) done_cnt <= done_cnt + 1;
    if (rx_miss) miss_cnt <= miss_cnt + 1;
  end

  function automatic int cap_of(int i);
    case (i)
      0: return 40;
      1: return 41;
      default: return 64;
    endcase
  endfunction
  function automatic logic [7:0] hadr_of(int i);
    return (i == 3) ? 8'h01 : 8'h00;
  endfunction
  function automatic int dw(int i, int k);
    return (BASE_BLK + i) * 4 + k;
  endfunction
  function automatic int bufw(int i);
    return 32'h200 + i * 32'h80;
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic arm_all();
    for (int i = 0; i < NDESC; i++) begin
      mem[dw(i, 0)] = 16'(bufw(i) * 2);
      mem[dw(i, 1)] = {8'h80, hadr_of(i)};
      mem[dw(i, 2)] = 16'(cap_of(i));
      mem[dw(i, 3)] = 16'hBEEF;
      owned[i] = 1'b1;
      for (int w = 0; w < 128; w++) mem[bufw(i) + w] = 16'h5A5A;
    end
  endtask

  task automatic disown(int i);
    mem[dw(i, 1)] = {8'h00, hadr_of(i)};
    owned[i] = 1'b0;
  endtask

  task automatic send_byte(logic [7:0] d, bit s, bit e, bit r);
    @(negedge clk);
    in_valid = 1'b1; in_data = d; in_sof = s; in_eof = e; in_err = r;
    #1;
    while (!in_ready) begin
      @(negedge clk);
      #1;
    end
    @(posedge clk);
  endtask

  function automatic logic [7:0] buf_byte(int i, int off);
    logic [15:0] w;
    w = mem[bufw(i) + off / 2];
    return (off % 2 == 1) ? w[15:8] : w[7:0];
  endfunction

  // send one frame, then predict and compare the descriptors it touched
  task automatic do_frame(int len, bit err, logic [7:0] seed);
    int idx = exp_idx, rem = len, off = 0, e_done = 0, e_miss = 0;
    int d0 = done_cnt, m0 = miss_cnt, w0 = wr_cnt;
    bit first = 1'b1;
    for (int k = 0; k < len; k++)
      send_byte(8'(seed + 8'(k)), k == 0, k == len - 1, err && (k == len - 1));
    @(negedge clk);
    in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0; in_err = 1'b0;
    repeat (20) @(negedge clk);
    if (!owned[idx]) begin
      e_miss = 1;
      check(wr_cnt == w0, "R2 no writes for unowned start", wr_cnt - w0, 0);
    end else begin
      forever begin
        int cap = cap_of(idx), n, nbad = 0, nxt = (idx + 1) % NDESC;
        logic [7:0] fl;
        bit last = (rem <= cap);
        n = last ? rem : cap;
        for (int b = 0; b < n; b++)
          if (buf_byte(idx, b) != 8'(seed + 8'(off + b))) nbad++;
        check(nbad == 0, "R3 buffer bytes", nbad, 0);
        if (n % 2 == 1)
          check(buf_byte(idx, n) == 8'h5A, "R3 lone byte lane", buf_byte(idx, n), 8'h5A);
        if (last) begin
          fl = 8'h01 | (first ? 8'h02 : 8'h00) | (err ? 8'h48 : 8'h00);
          check(mem[dw(idx, 1)] == {fl, hadr_of(idx)}, "R4 R6 R8 R11 end flags",
                mem[dw(idx, 1)], {fl, hadr_of(idx)});
          check(mem[dw(idx, 3)] == 16'(len), "R5 message length", mem[dw(idx, 3)], len);
          e_done = 1;
          idx = nxt;
          break;
        end
        check(mem[dw(idx, 3)] == 16'hBEEF, "R5 length untouched", mem[dw(idx, 3)], 16'hBEEF);
        if (owned[nxt]) begin
          fl = first ? 8'h02 : 8'h00;
          check(mem[dw(idx, 1)] == {fl, hadr_of(idx)}, "R4 R6 chained flags",
                mem[dw(idx, 1)], {fl, hadr_of(idx)});
          rem -= cap; off += cap; first = 1'b0; idx = nxt;
        end else begin
          fl = 8'h44 | (first ? 8'h02 : 8'h00);
          check(mem[dw(idx, 1)] == {fl, hadr_of(idx)}, "R7 no-buffer flags",
                mem[dw(idx, 1)], {fl, hadr_of(idx)});
          e_miss = 1;
          idx = nxt;
          break;
        end
      end
    end
    check(done_cnt - d0 == e_done, "R9 done pulses", done_cnt - d0, e_done);
    check(miss_cnt - m0 == e_miss, "R2 R7 miss pulses", miss_cnt - m0, e_miss);
    exp_idx = idx;
    arm_all();
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_bad++;
    $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    arm_all();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // reset state (R10)
    check(mem_req == 1'b0, "R10 reset mem_req", mem_req, 0);
    check(in_ready == 1'b1, "R10 reset ready", in_ready, 1);
    check(rx_done == 1'b0 && rx_miss == 1'b0, "R9 reset events", {rx_done, rx_miss}, 0);
    // stray bytes outside a frame (R10)
    begin
      int w0 = wr_cnt;
      for (int k = 0; k < 3; k++) send_byte(8'hE0 + 8'(k), 1'b0, k == 2, 1'b0);
      @(negedge clk); in_valid = 1'b0; in_eof = 1'b0;
      repeat (5) @(negedge clk);
      check(wr_cnt == w0, "R10 stray bytes ignored", wr_cnt - w0, 0);
    end
    // table of frames: wraps, chaining, odd lengths, error marker (R1 R3 R4 R5 R8)
    for (int f = 0; f < NFRAMES; f++)
      do_frame(int'(FRAMES[f][24:9]), FRAMES[f][8], FRAMES[f][7:0]);
    check(exp_idx == 3, "R1 index after table", exp_idx, 3);
    // unowned current descriptor at frame start (R2)
    disown(exp_idx);
    do_frame(5, 1'b0, 8'hC0);
    check(exp_idx == 3, "R2 index kept", exp_idx, 3);
    do_frame(5, 1'b0, 8'hC8);      // same descriptor now used (R1 wrap to 0 after)
    // chain into an unowned descriptor (R7)
    disown(1);
    do_frame(50, 1'b0, 8'hD0);
    // exact fit with unowned neighbour (R11)
    disown(2);
    do_frame(41, 1'b0, 8'hE0);
    do_frame(3, 1'b1, 8'hF0);
    check(exp_idx == 3, "R1 final index", exp_idx, 3);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule